// File: doc/BRIEF.md
# Bidirectional GPIO port controller

An eight-pin general-purpose I/O port for a microcontroller. Software sees two registers behind a one-bit address: a direction register and a data register. Each pin drives a tri-state pad through an output value and an output enable, and receives the pad level back. A peripheral may take over any pin with its own enable and value, and that takeover wins over the direction register.

The data register's output latch captures every write, whatever the direction, and is never cleared by reset. Software loads the latch first and then turns the pin into an output. Reading the data address returns the live pin level after a two-flop synchronizer, not the latch, so the value a peripheral drives can be read back. A low-power float control, in effect only while stop mode is active, releases every pad to high impedance and clamps the input path to 0 so a floating pad cannot leak.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While rst_ni is low, and after reset until a direction write, every direction bit is 0, so pad_oe_o is all zeros and a read at address 0 returns 0.
- R2: With direction bit 1, no peripheral enable and no clamp, pad_oe_o for that pin is 1 and pad_out_o equals the latched data bit.
- R3: With direction bit 0, no peripheral enable and no clamp, pad_oe_o for that pin is 0.
- R4: A write at address 1 (data) is captured in the latch whatever the direction; from the next cycle a pin whose direction is 1 drives the new bit, and a pin later set to direction 1 drives the bit written earlier.
- R5: Reset does not change the data latch: data written before a reset appears on the pins once direction is set after the reset.
- R6: A read at address 1 returns the gated pad input as sampled two rising edges earlier (two-flop synchronizer), the pin level and not the latch, in every mode.
- R7: With periph_oe_i set for a pin and no clamp, pad_oe_o is 1 and pad_out_o equals periph_out_i for that pin, whatever the direction bit; a read still returns the pin level.
- R8: When stop_i and float_en_i are both 1 (clamp), pad_oe_o is all zeros regardless of direction and peripheral enables, and the gated input is 0, so reads at address 1 return 0 from the second edge on.
- R9: stop_i alone or float_en_i alone has no effect on pad enables or the read path.
- R10: A read at address 0 returns the direction register; a write at address 0 takes effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 direction, 1 data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data |
| periph_oe_i | input | 8 | Per-pin peripheral output enable |
| periph_out_i | input | 8 | Per-pin peripheral output value |
| stop_i | input | 1 | Stop mode active |
| float_en_i | input | 1 | Float pins and clamp inputs while in stop |
| pad_in_i | input | 8 | Pad input level |
| pad_out_o | output | 8 | Pad output value |
| pad_oe_o | output | 8 | Pad output enable |

## Verification
A corrupted direction bit shows at once on pad_oe_o and on an address-0 read, in the cycle after the write that set it. A wrong latch bit is hidden while the pin is an input and surfaces only when direction is set, which is why the bench writes data before direction and across a reset. A fault in the synchronizer or the clamp gating shows on an address-1 read two edges after the pad or clamp changes.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned PORT_W = 8;
  localparam logic ADDR_DIR = 1'b0;
  localparam logic ADDR_DAT = 1'b1;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int unsigned W = gpio_pkg::PORT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic         addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] dat_o
);
  import gpio_pkg::*;

  logic dir_we, dat_we;
  assign dir_we = wr_en_i && (addr_i == ADDR_DIR);
  assign dat_we = wr_en_i && (addr_i == ADDR_DAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dir_o <= '0;
    else if (dir_we) dir_o <= wdata_i;
  end

  // output latch intentionally has no reset
  always_ff @(posedge clk_i) begin
    if (dat_we) dat_o <= wdata_i;
  end
endmodule

// File: rtl/gpio_out_mux.sv
module gpio_out_mux #(
  parameter int unsigned W = gpio_pkg::PORT_W
) (
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] dat_i,
  input  logic [W-1:0] periph_oe_i,
  input  logic [W-1:0] periph_out_i,
  input  logic         clamp_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      pad_out_o[i] = periph_oe_i[i] ? periph_out_i[i] : dat_i[i];
      if (clamp_i)             pad_oe_o[i] = 1'b0;
      else if (periph_oe_i[i]) pad_oe_o[i] = 1'b1;
      else                     pad_oe_o[i] = dir_i[i];
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = gpio_pkg::PORT_W,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pad_in_i,
  input  logic         clamp_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] gated;
  logic [W-1:0] stg [STAGES];

  assign gated = clamp_i ? '0 : pad_in_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '0;
    else         stg[0] <= gated;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else         stg[s] <= stg[s-1];
    end
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int unsigned W = gpio_pkg::PORT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic         addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic [W-1:0] periph_oe_i,
  input  logic [W-1:0] periph_out_i,
  input  logic         stop_i,
  input  logic         float_en_i,
  input  logic [W-1:0] pad_in_i,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_oe_o
);
  import gpio_pkg::*;

  logic [W-1:0] dir_q, dat_q, pin_sync;
  logic         clamp;

  assign clamp = stop_i & float_en_i;

  gpio_regs #(.W(W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .dir_o(dir_q), .dat_o(dat_q)
  );

  gpio_out_mux #(.W(W)) u_mux (
    .dir_i(dir_q), .dat_i(dat_q), .periph_oe_i(periph_oe_i),
    .periph_out_i(periph_out_i), .clamp_i(clamp),
    .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o)
  );

  gpio_in_sync #(.W(W), .STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pad_in_i(pad_in_i), .clamp_i(clamp),
    .sync_o(pin_sync)
  );

  assign rdata_o = (addr_i == ADDR_DIR) ? dir_q : pin_sync;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int unsigned W = gpio_pkg::PORT_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_en_i,
  input logic         addr_i,
  input logic [W-1:0] wdata_i,
  input logic [W-1:0] rdata_o,
  input logic [W-1:0] periph_oe_i,
  input logic [W-1:0] periph_out_i,
  input logic         stop_i,
  input logic         float_en_i,
  input logic [W-1:0] pad_in_i,
  input logic [W-1:0] pad_out_o,
  input logic [W-1:0] pad_oe_o
);
  logic         clamp_c;
  logic [W-1:0] gated_c;
  logic [1:0]   since_rst;

  assign clamp_c = stop_i & float_en_i;
  assign gated_c = clamp_c ? '0 : pad_in_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_reset_float_R1: assert property (@(posedge clk_i)
    !rst_ni |-> pad_oe_o == '0);

  assert_clamp_float_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_c |-> pad_oe_o == '0);

  assert_periph_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clamp_c |-> (((pad_oe_o & periph_oe_i) == periph_oe_i) &&
                  ((pad_out_o & periph_oe_i) == (periph_out_i & periph_oe_i))));

  assert_dat_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == gpio_pkg::ADDR_DAT) |=>
      (((pad_out_o ^ $past(wdata_i)) & pad_oe_o & ~periph_oe_i) == '0));

  assert_dir_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == gpio_pkg::ADDR_DIR) |=>
      (clamp_c || ((pad_oe_o & ~periph_oe_i) == ($past(wdata_i) & ~periph_oe_i))));

  assert_dir_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == gpio_pkg::ADDR_DIR) |=>
      (addr_i != gpio_pkg::ADDR_DIR || rdata_o == $past(wdata_i)));

  assert_pin_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3 && addr_i == gpio_pkg::ADDR_DAT) |->
      rdata_o == $past(gated_c, 2));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .periph_oe_i(periph_oe_i),
  .periph_out_i(periph_out_i), .stop_i(stop_i), .float_en_i(float_en_i),
  .pad_in_i(pad_in_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o)
);

// File: tb/tb_gpio_port_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_port_ctrl;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en = 1'b0;
  logic         addr = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [W-1:0] p_oe = '0, p_out = '0;
  logic         stop = 1'b0, flt = 1'b0;
  logic [W-1:0] ext = '0;
  logic [W-1:0] pad_in, pad_out, pad_oe;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] dir_m, dat_m;

  always #5 clk = ~clk;

  // pad model: driven bits loop back, others follow external level
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_port_ctrl #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .periph_oe_i(p_oe),
    .periph_out_i(p_out), .stop_i(stop), .float_en_i(flt),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  function automatic logic [W-1:0] exp_oe();
    if (stop && flt) return '0;
    return p_oe | dir_m;
  endfunction

  function automatic logic [W-1:0] exp_out();
    return (p_oe & p_out) | (~p_oe & dat_m);
  endfunction

  function automatic logic [W-1:0] exp_pin();
    logic [W-1:0] oe;
    oe = exp_oe();
    if (stop && flt) return '0;
    return (oe & exp_out()) | (~oe & ext);
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a) dat_m = d; else dir_m = d;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    logic [W-1:0] oe;
    oe = exp_oe();
    chk({tag, " oe"}, pad_oe, oe);
    chk({tag, " out"}, pad_out & oe, exp_out() & oe);
    addr = 1'b1; #1;
    chk({tag, " pin_rd"}, rdata, exp_pin());
    addr = 1'b0; #1;
    chk({tag, " dir_rd"}, rdata, dir_m);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1234_5678));
    dir_m = '0;
    dat_m = 'x;
    ext = 8'h3C;
    // R1: during and after reset
    #12;
    chk("R1 oe in reset", pad_oe, '0);
    @(negedge clk); rst_ni = 1'b1;
    settle();
    chk("R1 oe after reset", pad_oe, '0);
    addr = 1'b0; #1;
    chk("R1 dir read", rdata, '0);
    // R6: reads pin level while input
    addr = 1'b1; #1;
    chk("R6 read ext", rdata, 8'h3C);
    // R4: latch captured while input, driven only later
    wr(1'b1, 8'h5A);
    chk("R3 still float", pad_oe, '0);
    addr = 1'b1; #1;
    chk("R6 read is pin not latch", rdata, 8'h3C);
    wr(1'b0, 8'h0F);
    chk("R2 oe low nibble", pad_oe, 8'h0F);
    chk("R4 latched value driven", pad_out & 8'h0F, 8'h0A);
    settle();
    check_all("R6 mixed");
    // R5: reset keeps latch
    wr(1'b1, 8'hC3);
    @(negedge clk); rst_ni = 1'b0; dir_m = '0;
    #1 chk("R1 oe reset again", pad_oe, '0);
    @(negedge clk); rst_ni = 1'b1;
    wr(1'b0, 8'hFF);
    chk("R5 latch survives reset", pad_out, 8'hC3);
    settle();
    check_all("R5 all out");
    // R7: peripheral override
    p_oe = 8'hF0; p_out = 8'hA0; wr(1'b0, 8'h00);
    chk("R7 oe", pad_oe, 8'hF0);
    chk("R7 out", pad_out & 8'hF0, 8'hA0);
    settle();
    addr = 1'b1; #1;
    chk("R7 read periph level", rdata, 8'hA0 | (ext & 8'h0F));
    // R9: one of the two controls alone
    stop = 1'b1; #1;
    chk("R9 stop alone", pad_oe, 8'hF0);
    settle();
    check_all("R9 stop alone");
    stop = 1'b0; flt = 1'b1; #1;
    chk("R9 float alone", pad_oe, 8'hF0);
    settle();
    check_all("R9 float alone");
    // R8: clamp
    wr(1'b0, 8'hFF); ext = 8'hFF; stop = 1'b1; #1;
    chk("R8 all float", pad_oe, '0);
    settle();
    addr = 1'b1; #1;
    chk("R8 input clamped", rdata, '0);
    stop = 1'b0; flt = 1'b0;
    settle();
    check_all("R8 released");
    // random mix
    for (int i = 0; i < 300; i++) begin
      int unsigned r;
      r = $urandom;
      ext = W'($urandom);
      p_oe = (r[3:0] == 0) ? W'($urandom) : '0;
      p_out = W'($urandom);
      stop = r[4];
      flt = r[5] & r[6];
      if (r[7]) wr(1'b1, W'($urandom));
      if (r[8]) wr(1'b0, W'($urandom));
      settle();
      check_all(stop && flt ? "R8 rand" : (p_oe != 0 ? "R7 rand" : "R2 R3 R4 R10 rand"));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule